// File: doc/BRIEF.md
# Scaled-Index Integer Load Unit

This block carries out one 64-bit integer load at a time for a family of indexed load operations. The effective address is a base operand plus an index operand that has been scaled by a small power of two. A decoded operation arrives with an opcode, the destination and base register numbers, the two operand values and a 2-bit scale field. The opcode picks the access width, zero or sign extension, byte reversal, and whether the base register is updated.

The unit sends a single read over a valid/ready request channel and waits for a one-beat response. It then shapes the returned bytes into the destination value. The result is presented for one cycle together with the writeback enables, register numbers and values for the destination register and, in update forms, for the base register. Encodings that do not form a legal operation are rejected without any memory traffic and are reported on the same done pulse with the invalid flag raised.

Top module: `sxl_load_unit`

## Requirements
- R1: The request address equals base + (index << (sh+1)) modulo 2^64, where sh is the 2-bit `issue_sh` field, so the scale factor is 2, 4, 8 or 16. `mem_req_size` carries the size code of the opcode.
- R2: In a non-update form, a base register number of 0 uses the value zero as the base, whatever `issue_base_val` holds.
- R3: Opcode bits [1:0] select the size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. Response data is right-justified. A zero-extending load places the data in the low bytes of the result and clears every bit above it.
- R4: When opcode bit 2 (sign) is set on a 2- or 4-byte load, every result bit above the datum is a copy of the datum's most significant bit.
- R5: When opcode bit 3 (reverse) is set on a 2-, 4- or 8-byte load, the datum's bytes are placed in reversed order. Reversed 2- and 4-byte results are zero-extended. The response holds memory bytes big-endian, with the lowest address in the most significant byte of the datum.
- R6: When opcode bit 4 (update) is set on a legal form, the base writeback is enabled with the request address as its value and `issue_base` as its register number. It is asserted in the same cycle as the destination writeback of the loaded value.
- R7: An update form whose base register number is 0, or equals the destination register number, is invalid. It makes no memory request and asserts neither writeback enable.
- R8: Opcode combinations outside the family are invalid and are handled as in R7. These are: sign with a 1- or 8-byte size, and reverse together with a 1-byte size, with sign, or with update.
- R9: A request holds `mem_req_valid`, its address and its size stable until `mem_req_ready` is sampled high. At most one load is in flight, and `issue_ready` stays low from acceptance through the done cycle.
- R10: `done` is a single-cycle pulse. It rises in the cycle after the response is taken, or for an invalid operation in the cycle after acceptance. `invalid` is high only with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Operation offered |
| issue_ready | output | 1 | Unit idle and can take an operation |
| issue_op | input | 5 | {update, reverse, sign, size[1:0]} |
| issue_dst | input | 5 | Destination register number |
| issue_base | input | 5 | Base register number |
| issue_sh | input | 2 | Index scale field |
| issue_base_val | input | 64 | Base register contents |
| issue_index_val | input | 64 | Index register contents |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request taken |
| mem_req_addr | output | 64 | Read address |
| mem_req_size | output | 2 | Read size code |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data, right-justified |
| done | output | 1 | Operation finished |
| invalid | output | 1 | Operation was an invalid form |
| wb_dst_en | output | 1 | Destination writeback enable |
| wb_dst_num | output | 5 | Destination register number |
| wb_dst_val | output | 64 | Formatted load value |
| wb_base_en | output | 1 | Base writeback enable |
| wb_base_num | output | 5 | Base register number |
| wb_base_val | output | 64 | Effective address for the base register |

## Verification
In an update form the destination writeback and the base writeback fall on the same done cycle, and both must carry the right values at once. The bench provokes this with update loads whose address wraps past 2^64, and with loads in which request and response stalls are inserted. On the single done cycle it judges the formatted data, the address written to the base register and both register numbers. It also drives update forms in which the base equals the destination or is register 0. There the same cycle must show the invalid flag with both enables low.

// File: rtl/sxl_pkg.sv
package sxl_pkg;

    localparam int XLEN_DEF = 64;
    localparam int REGW_DEF = 5;
    localparam int SHW_DEF  = 2;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } size_e;

    // opcode layout, msb first: update, reverse, sign, size
    typedef struct packed {
        logic  upd;
        logic  rev;
        logic  sgn;
        size_e size;
    } lop_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } state_e;

    // true when the opcode is a member of the supported load family
    function automatic logic form_ok(lop_t op);
        if (op.sgn && (op.size == SZ_BYTE || op.size == SZ_DWORD))
            return 1'b0;
        if (op.rev && (op.size == SZ_BYTE || op.sgn || op.upd))
            return 1'b0;
        return 1'b1;
    endfunction

endpackage

// File: rtl/sxl_agen.sv
module sxl_agen
    import sxl_pkg::*;
#(
    parameter int XLEN = XLEN_DEF,
    parameter int REGW = REGW_DEF,
    parameter int SHW  = SHW_DEF
) (
    input  lop_t             op,
    input  logic [REGW-1:0]  dst,
    input  logic [REGW-1:0]  base,
    input  logic [SHW-1:0]   sh,
    input  logic [XLEN-1:0]  base_val,
    input  logic [XLEN-1:0]  index_val,
    output logic [XLEN-1:0]  ea,
    output logic             bad_form
);
    // one extra bit so that sh+1 never wraps
    localparam int AMTW = SHW + 1;

    logic [AMTW-1:0] amt;
    logic [XLEN-1:0] base_eff;
    logic            base_zero;

    always_comb begin
        base_zero = (base == '0);
        amt       = {1'b0, sh} + AMTW'(1);
        base_eff  = (!op.upd && base_zero) ? '0 : base_val;
        ea        = base_eff + (index_val << amt);
        bad_form  = !form_ok(op) || (op.upd && (base_zero || base == dst));
    end

endmodule

// File: rtl/sxl_fmt.sv
module sxl_fmt
    import sxl_pkg::*;
#(
    parameter int XLEN = XLEN_DEF
) (
    input  size_e            size,
    input  logic             sgn,
    input  logic             rev,
    input  logic [XLEN-1:0]  raw,
    output logic [XLEN-1:0]  result
);
    localparam int NB = XLEN / 8;

    int   nbytes;
    logic msb;
    logic [XLEN-1:0] lanes;

    // byte lanes: straight or mirrored within the accessed width
    always_comb begin
        nbytes = 1 << size;
        lanes  = '0;
        for (int i = 0; i < NB; i++) begin
            if (i < nbytes) begin
                if (rev)
                    lanes[i*8 +: 8] = raw[(nbytes-1-i)*8 +: 8];
                else
                    lanes[i*8 +: 8] = raw[i*8 +: 8];
            end
        end
        msb = lanes[nbytes*8-1];
    end

    // upper fill: zero or copies of the datum msb
    for (genvar g = 0; g < XLEN; g++) begin : g_fill
        always_comb begin
            if (g < nbytes*8)
                result[g] = lanes[g];
            else
                result[g] = sgn & msb;
        end
    end

endmodule

// File: rtl/sxl_ctrl.sv
module sxl_ctrl
    import sxl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   issue_valid,
    input  logic   bad_form,
    input  logic   mem_req_ready,
    input  logic   mem_rsp_valid,
    output logic   issue_ready,
    output logic   accept,
    output logic   capture,
    output logic   req_valid,
    output logic   done,
    output logic   bad_q
);
    state_e state;

    always_comb begin
        issue_ready = (state == ST_IDLE);
        accept      = issue_ready && issue_valid;
        req_valid   = (state == ST_REQ);
        capture     = (state == ST_WAIT) && mem_rsp_valid;
        done        = (state == ST_DONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            bad_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (issue_valid) begin
                    bad_q <= bad_form;
                    state <= bad_form ? ST_DONE : ST_REQ;
                end
                ST_REQ:  if (mem_req_ready) state <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid) state <= ST_DONE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done held"); // R10

    AST_NO_REQ_BAD: assert property (@(posedge clk) disable iff (rst)
        (accept && bad_form) |=> !req_valid) else $error("request on bad form"); // R7

endmodule

// File: rtl/sxl_load_unit.sv
module sxl_load_unit
    import sxl_pkg::*;
#(
    parameter int XLEN = XLEN_DEF,
    parameter int REGW = REGW_DEF,
    parameter int SHW  = SHW_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue_valid,
    output logic             issue_ready,
    input  logic [4:0]       issue_op,
    input  logic [REGW-1:0]  issue_dst,
    input  logic [REGW-1:0]  issue_base,
    input  logic [SHW-1:0]   issue_sh,
    input  logic [XLEN-1:0]  issue_base_val,
    input  logic [XLEN-1:0]  issue_index_val,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [XLEN-1:0]  mem_req_addr,
    output logic [1:0]       mem_req_size,
    input  logic             mem_rsp_valid,
    input  logic [XLEN-1:0]  mem_rsp_data,
    output logic             done,
    output logic             invalid,
    output logic             wb_dst_en,
    output logic [REGW-1:0]  wb_dst_num,
    output logic [XLEN-1:0]  wb_dst_val,
    output logic             wb_base_en,
    output logic [REGW-1:0]  wb_base_num,
    output logic [XLEN-1:0]  wb_base_val
);
    lop_t            op_in, op_q;
    logic [REGW-1:0] dst_q, base_q;
    logic [XLEN-1:0] ea, ea_q, fmt_val, res_q;
    logic            bad_form, bad_q, accept, capture;

    assign op_in = lop_t'(issue_op);

    sxl_agen #(.XLEN(XLEN), .REGW(REGW), .SHW(SHW)) agen_i (
        .op(op_in), .dst(issue_dst), .base(issue_base), .sh(issue_sh),
        .base_val(issue_base_val), .index_val(issue_index_val),
        .ea(ea), .bad_form(bad_form)
    );

    sxl_ctrl ctrl_i (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .bad_form(bad_form),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .issue_ready(issue_ready), .accept(accept), .capture(capture),
        .req_valid(mem_req_valid), .done(done), .bad_q(bad_q)
    );

    sxl_fmt #(.XLEN(XLEN)) fmt_i (
        .size(op_q.size), .sgn(op_q.sgn), .rev(op_q.rev),
        .raw(mem_rsp_data), .result(fmt_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= '0;
            dst_q  <= '0;
            base_q <= '0;
            ea_q   <= '0;
            res_q  <= '0;
        end else begin
            if (accept) begin
                op_q   <= op_in;
                dst_q  <= issue_dst;
                base_q <= issue_base;
                ea_q   <= ea;
            end
            if (capture)
                res_q <= fmt_val;
        end
    end

    always_comb begin
        mem_req_addr = ea_q;
        mem_req_size = op_q.size;
        invalid      = done && bad_q;
        wb_dst_en    = done && !bad_q;
        wb_base_en   = done && !bad_q && op_q.upd;
        wb_dst_num   = dst_q;
        wb_dst_val   = res_q;
        wb_base_num  = base_q;
        wb_base_val  = ea_q;
    end

    // address last handed over on the request channel
    logic [XLEN-1:0] sent_addr;
    always_ff @(posedge clk) begin
        if (rst)
            sent_addr <= '0;
        else if (mem_req_valid && mem_req_ready)
            sent_addr <= mem_req_addr;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_size)))
        else $error("request dropped"); // R9

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        issue_ready |-> !mem_req_valid) else $error("overlap"); // R9

    AST_INVALID_NO_WB: assert property (@(posedge clk) disable iff (rst)
        invalid |-> (!wb_dst_en && !wb_base_en)) else $error("wb on invalid"); // R7

    AST_BASE_WB_ADDR: assert property (@(posedge clk) disable iff (rst)
        wb_base_en |-> (wb_base_val == sent_addr && wb_dst_en))
        else $error("base wb mismatch"); // R6

    AST_INVALID_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        invalid |-> done) else $error("stray invalid"); // R10

endmodule

// File: tb/sxl_load_unit_tb.sv
module sxl_load_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_valid = 1'b0;
    logic        issue_ready;
    logic [4:0]  issue_op = '0;
    logic [4:0]  issue_dst = '0;
    logic [4:0]  issue_base = '0;
    logic [1:0]  issue_sh = '0;
    logic [63:0] issue_base_val = '0;
    logic [63:0] issue_index_val = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic [1:0]  mem_req_size;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        done, invalid, wb_dst_en, wb_base_en;
    logic [4:0]  wb_dst_num, wb_base_num;
    logic [63:0] wb_dst_val, wb_base_val;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    sxl_load_unit dut_i (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_ready(issue_ready),
        .issue_op(issue_op), .issue_dst(issue_dst), .issue_base(issue_base),
        .issue_sh(issue_sh), .issue_base_val(issue_base_val),
        .issue_index_val(issue_index_val), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_req_size(mem_req_size), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done(done), .invalid(invalid),
        .wb_dst_en(wb_dst_en), .wb_dst_num(wb_dst_num), .wb_dst_val(wb_dst_val),
        .wb_base_en(wb_base_en), .wb_base_num(wb_base_num), .wb_base_val(wb_base_val)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] model_val(logic [4:0] op, logic [63:0] d);
        logic [15:0] h;
        logic [31:0] w;
        logic [63:0] r;
        case (op[1:0])
            2'd0: r = {56'b0, d[7:0]};
            2'd1: begin
                h = op[3] ? {d[7:0], d[15:8]} : d[15:0];
                r = op[2] ? {{48{h[15]}}, h} : {48'b0, h};
            end
            2'd2: begin
                w = op[3] ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d[31:0];
                r = op[2] ? {{32{w[31]}}, w} : {32'b0, w};
            end
            default: begin
                r = d;
                if (op[3])
                    for (int k = 0; k < 8; k++) r[k*8 +: 8] = d[(7-k)*8 +: 8];
            end
        endcase
        return r;
    endfunction

    // one load: issue, request with req_lat stall cycles, response after rsp_lat cycles
    task automatic run_load(input string req, input logic [4:0] op, input logic [4:0] dst,
                            input logic [4:0] base, input logic [1:0] sh,
                            input logic [63:0] bval, input logic [63:0] xval,
                            input logic [63:0] data, input int req_lat, input int rsp_lat,
                            input bit exp_bad);
        logic [63:0] exp_ea;
        exp_ea = ((op[4] == 1'b0 && base == 5'd0) ? 64'd0 : bval) + (xval << (int'(sh) + 1));
        issue_op = op; issue_dst = dst; issue_base = base; issue_sh = sh;
        issue_base_val = bval; issue_index_val = xval; issue_valid = 1'b1;
        @(posedge clk); #1;
        issue_valid = 1'b0;
        chk(issue_ready == 1'b0, req, "busy after accept", {63'b0, issue_ready}, 64'd0);
        if (exp_bad) begin
            chk(mem_req_valid == 1'b0, req, "no request on invalid", {63'b0, mem_req_valid}, 64'd0);
            chk(done && invalid && !wb_dst_en && !wb_base_en, req, "invalid done {d,i,we,wb}",
                {60'b0, done, invalid, wb_dst_en, wb_base_en}, 64'hC);
        end else begin
            chk(mem_req_valid && mem_req_addr == exp_ea, "R1", "request address", mem_req_addr, exp_ea);
            chk(mem_req_size == op[1:0], "R1", "request size", {62'b0, mem_req_size}, {62'b0, op[1:0]});
            for (int i = 0; i < req_lat; i++) begin
                @(posedge clk); #1;
                chk(mem_req_valid && mem_req_addr == exp_ea, "R9", "request held", mem_req_addr, exp_ea);
            end
            mem_req_ready = 1'b1;
            @(posedge clk); #1;
            mem_req_ready = 1'b0;
            chk(mem_req_valid == 1'b0, "R9", "single request", {63'b0, mem_req_valid}, 64'd0);
            for (int i = 0; i < rsp_lat; i++) begin
                @(posedge clk); #1;
                chk(!done && !mem_req_valid, "R10", "waiting", {62'b0, done, mem_req_valid}, 64'd0);
            end
            mem_rsp_data = data; mem_rsp_valid = 1'b1;
            @(posedge clk); #1;
            mem_rsp_valid = 1'b0; mem_rsp_data = '0;
            chk(done && !invalid && wb_dst_en, "R10", "done {d,i,we}", {61'b0, done, invalid, wb_dst_en}, 64'h5);
            chk(wb_dst_val == model_val(op, data), req, "dst value", wb_dst_val, model_val(op, data));
            chk(wb_dst_num == dst, req, "dst number", {59'b0, wb_dst_num}, {59'b0, dst});
            chk(wb_base_en == op[4], "R6", "base enable", {63'b0, wb_base_en}, {63'b0, op[4]});
            if (op[4]) begin
                chk(wb_base_val == exp_ea, "R6", "base value", wb_base_val, exp_ea);
                chk(wb_base_num == base, "R6", "base number", {59'b0, wb_base_num}, {59'b0, base});
            end
        end
        @(posedge clk); #1;
        chk(!done && issue_ready, "R10", "done is a pulse", {62'b0, done, issue_ready}, 64'h1);
    endtask

    task automatic t_reset();
        chk(issue_ready && !done && !mem_req_valid && !wb_dst_en && !wb_base_en && !invalid,
            "R10", "reset state", {58'b0, issue_ready, done, mem_req_valid, wb_dst_en, wb_base_en, invalid},
            64'h20);
    endtask

    task automatic t_zero_ext();   // R3
        run_load("R3", 5'b00000, 5'd4, 5'd3, 2'd0, 64'h1000, 64'h8, 64'hFFFF_FFFF_FFFF_FFA5, 0, 0, 0);
        run_load("R3", 5'b00001, 5'd5, 5'd3, 2'd1, 64'h2000, 64'h3, 64'h1234_5678_9ABC_F00D, 1, 2, 0);
        run_load("R3", 5'b00010, 5'd6, 5'd7, 2'd2, 64'h0, 64'h11, 64'hFFFF_FFFF_8765_4321, 0, 1, 0);
        run_load("R3", 5'b00011, 5'd6, 5'd7, 2'd3, 64'h40, 64'h2, 64'hDEAD_BEEF_0BAD_CAFE, 0, 0, 0);
    endtask

    task automatic t_zero_base();  // R2
        run_load("R2", 5'b00010, 5'd9, 5'd0, 2'd3, 64'hFFFF_0000_0000_0000, 64'h5, 64'h0000_0000_CAFE_F00D, 0, 0, 0);
    endtask

    task automatic t_algebraic();  // R4
        run_load("R4", 5'b00101, 5'd2, 5'd1, 2'd0, 64'h100, 64'h1, 64'h0000_0000_0000_8001, 0, 0, 0);
        run_load("R4", 5'b00101, 5'd2, 5'd1, 2'd0, 64'h100, 64'h1, 64'hFFFF_FFFF_FFFF_7FFE, 0, 0, 0);
        run_load("R4", 5'b00110, 5'd2, 5'd1, 2'd1, 64'h100, 64'h1, 64'h0000_0000_F000_0001, 0, 0, 0);
        run_load("R4", 5'b00110, 5'd2, 5'd1, 2'd1, 64'h100, 64'h1, 64'hFFFF_FFFF_7000_0001, 0, 0, 0);
    endtask

    task automatic t_reverse();    // R5
        run_load("R5", 5'b01001, 5'd8, 5'd2, 2'd0, 64'h0, 64'h4, 64'h0000_0000_0000_80FF, 0, 0, 0);
        run_load("R5", 5'b01010, 5'd8, 5'd2, 2'd2, 64'h0, 64'h4, 64'h0000_0000_8A0B_0C0D, 0, 0, 0);
        run_load("R5", 5'b01011, 5'd8, 5'd2, 2'd1, 64'h0, 64'h4, 64'h0102_0304_0506_0788, 0, 0, 0);
    endtask

    task automatic t_update();     // R6, R1 wraparound
        run_load("R6", 5'b10010, 5'd3, 5'd4, 2'd3, 64'hFFFF_FFFF_FFFF_FFF0, 64'h1, 64'h0000_0000_1357_9BDF, 2, 1, 0);
        run_load("R6", 5'b10110, 5'd10, 5'd11, 2'd0, 64'h8000_0000_0000_0000, 64'h4000_0000_0000_0001, 64'h0000_0000_8000_0000, 0, 0, 0);
        run_load("R6", 5'b10011, 5'd31, 5'd30, 2'd2, 64'h77, 64'h3, 64'h0123_4567_89AB_CDEF, 0, 3, 0);
    endtask

    task automatic t_bad_update(); // R7
        run_load("R7", 5'b10010, 5'd3, 5'd0, 2'd0, 64'h10, 64'h1, 64'h0, 0, 0, 1);
        run_load("R7", 5'b10001, 5'd6, 5'd6, 2'd1, 64'h10, 64'h1, 64'h0, 0, 0, 1);
    endtask

    task automatic t_bad_combo();  // R8
        run_load("R8", 5'b00100, 5'd1, 5'd2, 2'd0, 64'h10, 64'h1, 64'h0, 0, 0, 1);
        run_load("R8", 5'b00111, 5'd1, 5'd2, 2'd0, 64'h10, 64'h1, 64'h0, 0, 0, 1);
        run_load("R8", 5'b01000, 5'd1, 5'd2, 2'd0, 64'h10, 64'h1, 64'h0, 0, 0, 1);
        run_load("R8", 5'b01110, 5'd1, 5'd2, 2'd0, 64'h10, 64'h1, 64'h0, 0, 0, 1);
        run_load("R8", 5'b11010, 5'd1, 5'd2, 2'd0, 64'h10, 64'h1, 64'h0, 0, 0, 1);
    endtask

    task automatic t_ignore_when_busy(); // R9: a second offer during a load is not taken
        issue_op = 5'b00011; issue_dst = 5'd12; issue_base = 5'd13; issue_sh = 2'd0;
        issue_base_val = 64'h500; issue_index_val = 64'h1; issue_valid = 1'b1;
        @(posedge clk); #1;
        issue_base_val = 64'h9999; issue_dst = 5'd20;
        @(posedge clk); #1;
        chk(mem_req_valid && mem_req_addr == 64'h502, "R9", "second offer ignored", mem_req_addr, 64'h502);
        issue_valid = 1'b0;
        mem_req_ready = 1'b1;
        @(posedge clk); #1;
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b1; mem_rsp_data = 64'h55;
        @(posedge clk); #1;
        mem_rsp_valid = 1'b0;
        chk(done && wb_dst_num == 5'd12 && wb_dst_val == 64'h55, "R9", "first load kept",
            wb_dst_val, 64'h55);
        @(posedge clk); #1;
        chk(issue_ready && !mem_req_valid, "R9", "idle after", {62'b0, issue_ready, mem_req_valid}, 64'h2);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #1;
        t_reset();
        t_zero_ext();
        t_zero_base();
        t_algebraic();
        t_reverse();
        t_update();
        t_bad_update();
        t_bad_combo();
        t_ignore_when_busy();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule